// File: doc/BRIEF.md
# Motor Drive Protection Supervisor

This block watches a brushless motor drive and decides when the commutation logic must stop driving. It merges four fault sources into three disable lines: a rotor that never reaches speed lock, a missing external speed reference clock, a low supply, and power-on reset. A stalled rotor trips a latch that only a deliberate stop or brake, held for a set number of timebase ticks, can release. A lost reference clock only blanks the PWM and recovers by itself when the clock returns, as long as the stall latch has not fired.

All timing uses a timebase tick, a one-cycle pulse on `tick`. The external clock is synchronised and watched for rising edges. The supply comparator and its hysteresis sit outside the block, so `uv_flag` arrives as a clean level. A state machine with four states holds the supervisor's view of the drive. ST_RESET is entered on `por` and left for ST_RUN once `por` drops (transition *reset release*). ST_RUN goes to ST_NOCLK when the clock watch reports a loss and the drive is in start (*clock lost*). ST_RUN or ST_NOCLK goes to ST_TRIP when the stall timer expires (*stall trip*). ST_NOCLK returns to ST_RUN when an edge comes back or stop is asserted (*clock resume*). ST_TRIP returns to ST_RUN when the release timer expires (*trip clear*). `por` forces ST_RESET from any state.

Top module: `drive_guard`

## Requirements
- R1: With `stop_req`=0, `brake_req`=0 and `lock_ok`=0 held for TRIP_TICKS ticks, `hs_off` goes to 1 within a few cycles of the last tick, and not after TRIP_TICKS-1 ticks. The trip stays latched.
- R2: A tick seen with `lock_ok`=1, `stop_req`=1 or `brake_req`=1 restarts the stall count from zero.
- R3: Once tripped, `hs_off` stays 1 until `stop_req` or `brake_req` has been held for CLEAR_TICKS consecutive ticks. A hold that breaks off restarts that count, and `lock_ok` returning has no effect on the latch.
- R4: In start (`stop_req`=0) with no rising edge on `ext_clk` for CLK_LOSS_TICKS ticks, `pwm_inhibit` goes to 1. After CLK_LOSS_TICKS-1 ticks it is still 0.
- R5: If rising edges on `ext_clk` return before a trip, `pwm_inhibit` drops by itself. After a trip, the return of the clock leaves `hs_off` at 1.
- R6: A clock loss while `stop_req`=1 does not raise `pwm_inhibit`, and asserting `stop_req` during an inhibit releases it.
- R7: `uv_flag`=1 sets `all_off` in the same cycle and leaves the internal state untouched. When it drops, the previous output returns.
- R8: While `por`=1, `all_off` is 1. After `por` is released, the trip latch, stall count and clock-loss count are all back at zero.
- R9: At most one output is 1 at a time, in the priority `por`, then `uv_flag` (both on `all_off`), then the trip (`hs_off`), then clock loss (`pwm_inhibit`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase pulse, one cycle wide |
| lock_ok | input | 1 | 1 when the motor speed is inside the lock window |
| stop_req | input | 1 | 1 = stop, 0 = start |
| brake_req | input | 1 | 1 = brake applied |
| ext_clk | input | 1 | External speed reference clock, asynchronous |
| uv_flag | input | 1 | 1 = supply below the undervoltage threshold |
| por | input | 1 | Power-on reset, active high |
| hs_off | output | 1 | High-side drivers off because of a latched stall trip |
| pwm_inhibit | output | 1 | PWM blanked because the reference clock is missing |
| all_off | output | 1 | Every driver off (power-on reset or undervoltage) |

## Verification
A wrong state register shows up on the outputs within one cycle. A stuck ST_TRIP keeps `hs_off` high through a full stop or brake hold, and a missed ST_NOCLK leaves `pwm_inhibit` low after the loss count. An off-by-one in any of the three tick counters moves an output change by exactly one tick, so the bench probes each threshold one tick below and at the limit. A priority fault puts two outputs high together during undervoltage or reset.

// File: rtl/dg_pkg.sv
package dg_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_NOCLK = 2'd2,
        ST_TRIP  = 2'd3
    } guard_state_e;
endpackage

// File: rtl/dg_tick_timer.sv
// Saturating tick counter; done when LIMIT ticks have been counted since clr.
module dg_tick_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);

    // R1 / R3: the count never passes its limit and stays saturated
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);
endmodule

// File: rtl/dg_clk_watch.sv
// Synchronises the external clock and counts ticks since its last rising edge.
module dg_clk_watch #(
    parameter int LOSS_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ext_clk,
    input  logic tick,
    output logic lost
);
    localparam int W = $clog2(LOSS_TICKS + 1);
    localparam logic [W-1:0] LIM = W'(LOSS_TICKS);

    logic [2:0]   sync_q;
    logic         rise;
    logic [W-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ext_clk};
        end
    end

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (clr || rise) begin
            gap_cnt <= '0;
        end else if (tick && gap_cnt != LIM) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign lost = (gap_cnt == LIM);

    // R5: a detected edge rearms the watch
    assert_edge_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !lost);
endmodule

// File: rtl/drive_guard.sv
module drive_guard
    import dg_pkg::*;
#(
    parameter int CLK_LOSS_TICKS = 64,
    parameter int TRIP_TICKS     = 300000,
    parameter int CLEAR_TICKS    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lock_ok,
    input  logic stop_req,
    input  logic brake_req,
    input  logic ext_clk,
    input  logic uv_flag,
    input  logic por,
    output logic hs_off,
    output logic pwm_inhibit,
    output logic all_off
);
    guard_state_e state, state_nxt;
    logic trip_done, clear_done, clk_lost;
    logic hold_req, stall_clr, clear_clr;

    assign hold_req  = stop_req | brake_req;
    assign stall_clr = por | lock_ok | hold_req
                     | (state == ST_TRIP) | (state == ST_RESET);
    assign clear_clr = por | (state != ST_TRIP) | !hold_req;

    dg_tick_timer #(.LIMIT(TRIP_TICKS)) u_stall (
        .clk(clk), .rst_n(rst_n), .clr(stall_clr), .tick(tick), .done(trip_done)
    );

    dg_tick_timer #(.LIMIT(CLEAR_TICKS)) u_clear (
        .clk(clk), .rst_n(rst_n), .clr(clear_clr), .tick(tick), .done(clear_done)
    );

    dg_clk_watch #(.LOSS_TICKS(CLK_LOSS_TICKS)) u_watch (
        .clk(clk), .rst_n(rst_n), .clr(por), .ext_clk(ext_clk), .tick(tick), .lost(clk_lost)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
        end else if (por) begin
            state <= ST_RESET;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET: state_nxt = ST_RUN;
            ST_RUN: begin
                if (trip_done)                  state_nxt = ST_TRIP;
                else if (clk_lost && !stop_req) state_nxt = ST_NOCLK;
            end
            ST_NOCLK: begin
                if (trip_done)                  state_nxt = ST_TRIP;
                else if (!clk_lost || stop_req) state_nxt = ST_RUN;
            end
            ST_TRIP: begin
                if (clear_done)                 state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RESET;
        endcase
    end

    always_comb begin
        all_off     = por | uv_flag | (state == ST_RESET);
        hs_off      = 1'b0;
        pwm_inhibit = 1'b0;
        if (!all_off) begin
            unique case (state)
                ST_TRIP:  hs_off      = 1'b1;
                ST_NOCLK: pwm_inhibit = 1'b1;
                default:  ;
            endcase
        end
    end

    // R1: the trip state is only entered after the stall timer expired
    assert_trip_cause_R1: assert property (@(posedge clk) disable iff (!rst_n || por)
        (state == ST_TRIP && $past(state) != ST_TRIP) |-> $past(trip_done));
    // R3: without a stop or brake hold the latch persists
    assert_trip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || por)
        (state == ST_TRIP && !hold_req) |=> state == ST_TRIP);
    // R5: a returning clock ends the inhibit
    assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n || por)
        (state == ST_NOCLK && !clk_lost && !trip_done) |=> state == ST_RUN);
    // R6: stop releases the clock-loss inhibit
    assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n || por)
        (state == ST_NOCLK && stop_req && !trip_done) |=> state == ST_RUN);
    // R8: the cycle after power-on reset keeps every driver off
    assert_por_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(por) |-> all_off);
    // R9: outputs never overlap
    assert_single_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({all_off, hs_off, pwm_inhibit}));
endmodule

// File: tb/drive_guard_tb.sv
module drive_guard_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, tick, lock_ok, stop_req, brake_req, ext_clk, uv_flag, por;
    logic hs_off, pwm_inhibit, all_off;
    logic clk_run;
    int n_chk = 0;
    int n_fail = 0;

    drive_guard #(.CLK_LOSS_TICKS(4), .TRIP_TICKS(12), .CLEAR_TICKS(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lock_ok(lock_ok),
        .stop_req(stop_req), .brake_req(brake_req), .ext_clk(ext_clk),
        .uv_flag(uv_flag), .por(por),
        .hs_off(hs_off), .pwm_inhibit(pwm_inhibit), .all_off(all_off)
    );

    // {stop, brake, lock, uv, ticks[4:0], expected {all_off, hs_off, pwm_inhibit}}
    localparam logic [11:0] VEC [0:12] = '{
        {4'b1010, 5'd2,  3'b000},  // R2 stopped, nothing counts
        {4'b0000, 5'd6,  3'b000},  // R1 half the stall window
        {4'b0010, 5'd1,  3'b000},  // R2 lock restarts count
        {4'b0000, 5'd11, 3'b000},  // R2 one tick short
        {4'b0100, 5'd1,  3'b000},  // R2 brake restarts count
        {4'b0000, 5'd11, 3'b000},  // R1 one tick short
        {4'b0000, 5'd1,  3'b010},  // R1 trip
        {4'b0001, 5'd0,  3'b100},  // R9 undervoltage wins
        {4'b0010, 5'd3,  3'b010},  // R3 lock does not clear
        {4'b1010, 5'd4,  3'b010},  // R3 hold short of limit
        {4'b0010, 5'd1,  3'b010},  // R3 hold broken
        {4'b0110, 5'd4,  3'b010},  // R3 restarted hold
        {4'b0110, 5'd1,  3'b000}   // R3 released
    };
    localparam int VREQ [0:12] = '{2, 1, 2, 2, 2, 1, 1, 9, 3, 3, 3, 3, 3};

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {all_off, hs_off, pwm_inhibit};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {all_off,hs_off,pwm_inhibit} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            if (clk_run) ext_clk = ~ext_clk;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        report();
    end

    initial begin
        rst_n = 1'b0; por = 1'b1; tick = 1'b0; lock_ok = 1'b1; stop_req = 1'b1;
        brake_req = 1'b0; ext_clk = 1'b0; uv_flag = 1'b0; clk_run = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R8 por held", 3'b100);
        por = 1'b0;
        settle();
        check("R8 reset release", 3'b000);
        step(2);

        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            {stop_req, brake_req, lock_ok, uv_flag} = VEC[i][11:8];
            step(int'(VEC[i][7:3]));
            settle();
            check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][2:0]);
        end

        // R4 clock loss boundary
        @(negedge clk);
        brake_req = 1'b0; stop_req = 1'b0; lock_ok = 1'b1; clk_run = 1'b0;
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        settle();
        step(3); settle();
        check("R4 one tick short", 3'b000);
        step(1); settle();
        check("R4 clock lost", 3'b001);

        // R7 undervoltage masks without state change
        uv_flag = 1'b1;
        @(negedge clk);
        check("R7 uv on", 3'b100);
        uv_flag = 1'b0;
        @(negedge clk);
        check("R7 uv off", 3'b001);

        // R5 clock returns
        clk_run = 1'b1;
        step(2); settle();
        check("R5 resume", 3'b000);

        // R6 loss while stopped
        stop_req = 1'b1; clk_run = 1'b0;
        step(6); settle();
        check("R6 stopped loss", 3'b000);
        stop_req = 1'b0;
        settle();
        check("R6 start without clock", 3'b001);
        stop_req = 1'b1;
        settle();
        check("R6 stop releases", 3'b000);

        // R5 trip during clock loss
        stop_req = 1'b0; lock_ok = 1'b0;
        settle();
        step(11); settle();
        check("R5 inhibited before trip", 3'b001);
        step(1); settle();
        check("R1 trip during loss", 3'b010);
        clk_run = 1'b1;
        step(4); settle();
        check("R5 clock back after trip", 3'b010);
        stop_req = 1'b1;
        step(5); settle();
        check("R3 stop clears", 3'b000);

        // R8 por clears a trip
        stop_req = 1'b0;
        step(12); settle();
        check("R1 second trip", 3'b010);
        por = 1'b1;
        @(negedge clk);
        check("R8 por on", 3'b100);
        repeat (2) @(negedge clk);
        por = 1'b0;
        settle();
        check("R8 trip cleared", 3'b000);

        report();
    end
endmodule